// File: doc/BRIEF.md
# Precise Trap Capture Unit for a Five-Stage Pipeline

This block sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and turns exception requests and an external interrupt line into a precise trap. Decode can report an undefined opcode or a return-from-trap. Execute can report an arithmetic overflow or a system call. Each stage supplies the PC of the instruction it holds. When a trap is taken, the unit saves the PC of the instruction that will restart, records a cause code and clears the interrupt enable. In the next cycle it asserts, all in the same cycle, a per-stage flush mask and a fetch redirect to a fixed handler address.

All outputs are registered, so the flush reaches the pipeline one cycle after the request. By then the victim instruction has moved one stage further down. The flush mask therefore covers the stage the victim now occupies and every younger stage. No victim and no younger instruction ever reaches writeback or a store. The flush bit for the memory stage doubles as the writeback suppression for a faulting execute-stage instruction.

A return-from-trap seen in decode redirects fetch back to the saved PC and flushes the instructions fetched behind it. It does not change the saved state.

Top module: `trap_capture`

## Requirements
- R1: While and just after reset: `epc_o`=0, `cause_o`=0, `ie_o`=0, `flush_o`=0, `redirect_o`=0.
- R2: An execute-stage fault (`ex_valid_i` with `ex_ovf_i` or `ex_sys_i`) produces the following one cycle later: `epc_o`=`ex_pc_i`, `cause_o`=2 for overflow or 3 for system call (overflow wins if both are set), and `flush_o`=4'b1111. Flush bit 0 is fetch, bit 1 decode, bit 2 execute and bit 3 memory; bit 3 suppresses the faulting instruction's writeback.
- R3: A decode-stage undefined opcode (`id_valid_i` and `id_undef_i`) produces the following one cycle later: `epc_o`=`id_pc_i`, `cause_o`=1 and `flush_o`=4'b0111. The older instruction in memory is left alone.
- R4: When several events arrive in the same cycle, the execute-stage fault wins over the interrupt, and the interrupt wins over the decode-stage undefined opcode.
- R5: An interrupt (`irq_i` while `ie_o`=1) records `cause_o`=0. The saved PC is the oldest instruction that has not completed. If execute is valid, `epc_o`=`ex_pc_i` and `flush_o`=4'b1111. Otherwise, if decode is valid, `epc_o`=`id_pc_i` and `flush_o`=4'b0111. Otherwise `epc_o`=`if_pc_i` and `flush_o`=4'b0011.
- R6: Taking any trap clears `ie_o` in the next cycle. A pulse on `ie_set_i` sets it. If both happen in the same cycle, the trap wins.
- R7: A taken trap raises `redirect_o` for exactly one cycle with `redirect_pc_o`=HANDLER_PC, in the same cycle as its flush mask.
- R8: Any request presented while `redirect_o` is high comes from an instruction being flushed and is ignored: `epc_o`, `cause_o` and `redirect_o` are unchanged or low in the next cycle.
- R9: While `ie_o`=0, `irq_i` has no effect.
- R10: A return-from-trap (`id_valid_i` and `id_eret_i`) with no other event pending produces the following one cycle later: `redirect_o`=1, `redirect_pc_o`=`epc_o` and `flush_o`=4'b0011, with `epc_o`, `cause_o` and `ie_o` unchanged. Any trap in the same cycle wins over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_pc_i | input | PC_W | PC of the instruction being fetched |
| id_valid_i | input | 1 | Decode stage holds a live instruction |
| id_pc_i | input | PC_W | PC of the decode-stage instruction |
| id_undef_i | input | 1 | Decode found an undefined opcode |
| id_eret_i | input | 1 | Decode found a return-from-trap |
| ex_valid_i | input | 1 | Execute stage holds a live instruction |
| ex_pc_i | input | PC_W | PC of the execute-stage instruction |
| ex_ovf_i | input | 1 | Execute arithmetic overflow |
| ex_sys_i | input | 1 | Execute-stage system call |
| irq_i | input | 1 | External interrupt request (level) |
| ie_set_i | input | 1 | Pulse that sets the interrupt enable |
| epc_o | output | PC_W | Saved restart PC |
| cause_o | output | 2 | Cause: 0 irq, 1 undefined, 2 overflow, 3 syscall |
| ie_o | output | 1 | Interrupt enable |
| flush_o | output | 4 | Per-stage kill: bit0 fetch, bit1 decode, bit2 execute, bit3 memory |
| redirect_o | output | 1 | One-cycle fetch redirect |
| redirect_pc_o | output | PC_W | Redirect target |

## Verification
The bench builds the unit with PC_W=16 and HANDLER_PC=16'h0A00. The narrower PC exercises width derivation through every submodule. The non-default handler address proves the redirect target comes from the parameter and not from a literal. Every PC the bench drives is distinct, so a wrong stage selection in the interrupt fallback chain or in the priority order shows up directly as a wrong saved PC.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    CAUSE_IRQ   = 2'd0,
    CAUSE_UNDEF = 2'd1,
    CAUSE_OVF   = 2'd2,
    CAUSE_SYS   = 2'd3
  } cause_e;

  localparam int STG_IF  = 0;
  localparam int STG_ID  = 1;
  localparam int STG_EX  = 2;
  localparam int STG_MEM = 3;
  localparam int N_FLUSH = 4;

  typedef logic [1:0] stage_t;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            busy,
  input  logic            ie,
  input  logic [PC_W-1:0] if_pc,
  input  logic            id_valid,
  input  logic [PC_W-1:0] id_pc,
  input  logic            id_undef,
  input  logic            id_eret,
  input  logic            ex_valid,
  input  logic [PC_W-1:0] ex_pc,
  input  logic            ex_ovf,
  input  logic            ex_sys,
  input  logic            irq,
  output logic            take,
  output logic            ret,
  output cause_e          code,
  output logic [PC_W-1:0] pc,
  output stage_t          victim
);
  logic ex_hit, int_hit, id_hit;

  // Oldest first: execute fault, then interrupt boundary, then decode fault.
  assign ex_hit  = !busy && ex_valid && (ex_ovf || ex_sys);
  assign int_hit = !busy && irq && ie && !ex_hit;
  assign id_hit  = !busy && id_valid && id_undef && !ex_hit && !int_hit;
  assign take    = ex_hit || int_hit || id_hit;
  assign ret     = !busy && id_valid && id_eret && !take;

  always_comb begin
    code   = CAUSE_IRQ;
    pc     = if_pc;
    victim = stage_t'(STG_IF);
    if (ex_hit) begin
      code   = ex_ovf ? CAUSE_OVF : CAUSE_SYS;
      pc     = ex_pc;
      victim = stage_t'(STG_EX);
    end else if (int_hit) begin
      code = CAUSE_IRQ;
      if (ex_valid) begin
        pc     = ex_pc;
        victim = stage_t'(STG_EX);
      end else if (id_valid) begin
        pc     = id_pc;
        victim = stage_t'(STG_ID);
      end
    end else if (id_hit) begin
      code   = CAUSE_UNDEF;
      pc     = id_pc;
      victim = stage_t'(STG_ID);
    end
  end
endmodule

// File: rtl/trap_state.sv
module trap_state
  import trap_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  cause_e          code,
  input  logic [PC_W-1:0] pc,
  input  logic            ie_set,
  output logic [PC_W-1:0] epc,
  output cause_e          cause,
  output logic            ie
);
  always_ff @(posedge clk) begin
    if (rst) begin
      epc   <= '0;
      cause <= CAUSE_IRQ;
      ie    <= 1'b0;
    end else begin
      if (take) begin
        epc   <= pc;
        cause <= code;
        ie    <= 1'b0;
      end else if (ie_set) begin
        ie <= 1'b1;
      end
    end
  end

  AST_IE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    take |=> !ie); // R6
  AST_STATE_HELD: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(epc) && $stable(cause))); // R8
endmodule

// File: rtl/trap_steer.sv
module trap_steer
  import trap_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 'h100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic               ret,
  input  stage_t             victim,
  input  logic [PC_W-1:0]    epc,
  output logic [N_FLUSH-1:0] flush,
  output logic               redirect,
  output logic [PC_W-1:0]    redirect_pc
);
  logic [N_FLUSH-1:0] trap_mask;
  logic [N_FLUSH-1:0] ret_mask;

  // The victim advances one stage before the flush lands, so kill up to victim+1.
  for (genvar k = 0; k < N_FLUSH; k++) begin : g_mask
    assign trap_mask[k] = (k <= int'(victim) + 1);
    assign ret_mask[k]  = (k <= STG_ID);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flush       <= '0;
      redirect    <= 1'b0;
      redirect_pc <= '0;
    end else begin
      redirect <= take || ret;
      if (take) begin
        flush       <= trap_mask;
        redirect_pc <= HANDLER_PC;
      end else if (ret) begin
        flush       <= ret_mask;
        redirect_pc <= epc;
      end else begin
        flush <= '0;
      end
    end
  end

  AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !redirect); // R7
  AST_FLUSH_PAIRED: assert property (@(posedge clk) disable iff (rst)
    (flush != '0) == redirect); // R7
  AST_FLUSH_THERMO: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (flush[0] && flush[1] && !(flush[3] && !flush[2]))); // R5
endmodule

// File: rtl/trap_capture.sv
module trap_capture
  import trap_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 'h100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] if_pc_i,
  input  logic            id_valid_i,
  input  logic [PC_W-1:0] id_pc_i,
  input  logic            id_undef_i,
  input  logic            id_eret_i,
  input  logic            ex_valid_i,
  input  logic [PC_W-1:0] ex_pc_i,
  input  logic            ex_ovf_i,
  input  logic            ex_sys_i,
  input  logic            irq_i,
  input  logic            ie_set_i,
  output logic [PC_W-1:0] epc_o,
  output logic [1:0]      cause_o,
  output logic            ie_o,
  output logic [3:0]      flush_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o
);
  logic            take, ret;
  cause_e          code, cause_q;
  logic [PC_W-1:0] cand_pc;
  stage_t          victim;

  trap_arbiter #(.PC_W(PC_W)) u_arb (
    .busy(redirect_o), .ie(ie_o), .if_pc(if_pc_i),
    .id_valid(id_valid_i), .id_pc(id_pc_i), .id_undef(id_undef_i), .id_eret(id_eret_i),
    .ex_valid(ex_valid_i), .ex_pc(ex_pc_i), .ex_ovf(ex_ovf_i), .ex_sys(ex_sys_i),
    .irq(irq_i), .take(take), .ret(ret), .code(code), .pc(cand_pc), .victim(victim)
  );

  trap_state #(.PC_W(PC_W)) u_state (
    .clk(clk), .rst(rst), .take(take), .code(code), .pc(cand_pc),
    .ie_set(ie_set_i), .epc(epc_o), .cause(cause_q), .ie(ie_o)
  );

  trap_steer #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_steer (
    .clk(clk), .rst(rst), .take(take), .ret(ret), .victim(victim), .epc(epc_o),
    .flush(flush_o), .redirect(redirect_o), .redirect_pc(redirect_pc_o)
  );

  assign cause_o = cause_q;

  AST_EX_FAULT_KILLS_WB: assert property (@(posedge clk) disable iff (rst)
    (!redirect_o && ex_valid_i && (ex_ovf_i || ex_sys_i))
      |=> (flush_o == 4'b1111 && cause_o != 2'd0 && cause_o != 2'd1)); // R2
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!ie_o && !(ex_valid_i && (ex_ovf_i || ex_sys_i)) &&
     !(id_valid_i && (id_undef_i || id_eret_i))) |=> !redirect_o); // R9
  AST_HANDLER_TARGET: assert property (@(posedge clk) disable iff (rst)
    (redirect_o && flush_o[2]) |-> (redirect_pc_o == HANDLER_PC)); // R7
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
    redirect_o |=> ($stable(epc_o) && $stable(cause_o))); // R8
endmodule

// File: tb/sim_trap_capture.sv
`timescale 1ns/1ps
module sim_trap_capture;
  localparam int              PC_W = 16;
  localparam logic [PC_W-1:0] HPC  = 16'h0A00;

  logic clk = 1'b0;
  logic rst;
  logic [PC_W-1:0] if_pc, id_pc, ex_pc;
  logic id_valid, id_undef, id_eret, ex_valid, ex_ovf, ex_sys, irq, ie_set;
  logic [PC_W-1:0] epc, rpc;
  logic [1:0] cause;
  logic ie, redirect;
  logic [3:0] flush;
  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  trap_capture #(.PC_W(PC_W), .HANDLER_PC(HPC)) u0 (
    .clk(clk), .rst(rst), .if_pc_i(if_pc), .id_valid_i(id_valid), .id_pc_i(id_pc),
    .id_undef_i(id_undef), .id_eret_i(id_eret), .ex_valid_i(ex_valid), .ex_pc_i(ex_pc),
    .ex_ovf_i(ex_ovf), .ex_sys_i(ex_sys), .irq_i(irq), .ie_set_i(ie_set),
    .epc_o(epc), .cause_o(cause), .ie_o(ie), .flush_o(flush),
    .redirect_o(redirect), .redirect_pc_o(rpc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    if_pc = 16'h0300; id_pc = 16'h0200; ex_pc = 16'h0100;
    id_valid = 0; id_undef = 0; id_eret = 0;
    ex_valid = 0; ex_ovf = 0; ex_sys = 0; irq = 0; ie_set = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic enable_irq();
    ie_set = 1; step(); idle();
    chk("R6 ie set", 32'(ie), 1);
  endtask

  task automatic t_reset();
    idle(); rst = 1;
    repeat (3) step();
    chk("R1 redirect in reset", 32'(redirect), 0);
    rst = 0;
    chk("R1 epc", 32'(epc), 0);
    chk("R1 cause", 32'(cause), 0);
    chk("R1 ie", 32'(ie), 0);
    chk("R1 flush", 32'(flush), 0);
  endtask

  task automatic t_ex_ovf();
    ex_valid = 1; ex_pc = 16'h1040; ex_ovf = 1; ex_sys = 1;
    step(); idle();
    chk("R2 ovf epc", 32'(epc), 32'h1040);
    chk("R2 ovf wins cause", 32'(cause), 2);
    chk("R2 flush incl wb", 32'(flush), 4'b1111);
    chk("R7 redirect", 32'(redirect), 1);
    chk("R7 handler pc", 32'(rpc), 32'(HPC));
    step();
    chk("R7 one-cycle redirect", 32'(redirect), 0);
    chk("R7 flush drops", 32'(flush), 0);
  endtask

  task automatic t_ex_sys();
    ex_valid = 1; ex_pc = 16'h1088; ex_sys = 1;
    step(); idle();
    chk("R2 sys epc", 32'(epc), 32'h1088);
    chk("R2 sys cause", 32'(cause), 3);
    step();
  endtask

  task automatic t_id_undef();
    id_valid = 1; id_pc = 16'h2004; id_undef = 1;
    step(); idle();
    chk("R3 epc", 32'(epc), 32'h2004);
    chk("R3 cause", 32'(cause), 1);
    chk("R3 flush keeps mem", 32'(flush), 4'b0111);
    step();
  endtask

  task automatic t_busy_ignore();
    ex_valid = 1; ex_pc = 16'h3000; ex_ovf = 1;
    step(); idle();
    id_valid = 1; id_pc = 16'h3333; id_undef = 1; id_eret = 1;
    step(); idle();
    chk("R8 epc kept", 32'(epc), 32'h3000);
    chk("R8 cause kept", 32'(cause), 2);
    chk("R8 no redirect", 32'(redirect), 0);
    step();
  endtask

  task automatic t_irq_masked();
    irq = 1; ex_valid = 1; ex_pc = 16'h4000;
    step(); idle();
    chk("R9 masked no redirect", 32'(redirect), 0);
    chk("R9 epc untouched", 32'(epc), 32'h3000);
  endtask

  task automatic t_irq_ex();
    enable_irq();
    irq = 1; ex_valid = 1; ex_pc = 16'h4010; id_valid = 1; id_pc = 16'h4014;
    step(); idle();
    chk("R5 irq ex epc", 32'(epc), 32'h4010);
    chk("R5 irq cause", 32'(cause), 0);
    chk("R5 irq ex flush", 32'(flush), 4'b1111);
    chk("R6 ie cleared", 32'(ie), 0);
    step();
  endtask

  task automatic t_irq_id();
    enable_irq();
    irq = 1; id_valid = 1; id_pc = 16'h4024; if_pc = 16'h4028;
    step(); idle();
    chk("R5 irq id epc", 32'(epc), 32'h4024);
    chk("R5 irq id flush", 32'(flush), 4'b0111);
    step();
  endtask

  task automatic t_irq_if();
    enable_irq();
    irq = 1; if_pc = 16'h4038;
    step(); idle();
    chk("R5 irq if epc", 32'(epc), 32'h4038);
    chk("R5 irq if flush", 32'(flush), 4'b0011);
    step();
  endtask

  task automatic t_priority();
    enable_irq();
    irq = 1; ex_valid = 1; ex_pc = 16'h5000; ex_sys = 1; id_valid = 1; id_pc = 16'h5004; id_undef = 1;
    step(); idle();
    chk("R4 ex beats irq epc", 32'(epc), 32'h5000);
    chk("R4 ex beats irq cause", 32'(cause), 3);
    step();
    enable_irq();
    irq = 1; id_valid = 1; id_pc = 16'h5104; id_undef = 1;
    step(); idle();
    chk("R4 irq beats undef cause", 32'(cause), 0);
    chk("R4 irq beats undef epc", 32'(epc), 32'h5104);
    step();
  endtask

  task automatic t_ie_race();
    enable_irq();
    irq = 1; ie_set = 1; if_pc = 16'h6000;
    step(); idle();
    chk("R6 trap beats ie_set", 32'(ie), 0);
    step();
    chk("R6 stays clear", 32'(ie), 0);
  endtask

  task automatic t_eret();
    id_valid = 1; id_pc = 16'h0A40; id_eret = 1;
    step(); idle();
    chk("R10 redirect", 32'(redirect), 1);
    chk("R10 target epc", 32'(rpc), 32'h6000);
    chk("R10 flush", 32'(flush), 4'b0011);
    chk("R10 cause kept", 32'(cause), 0);
    step();
    ex_valid = 1; ex_pc = 16'h0A50; ex_ovf = 1; id_valid = 1; id_eret = 1;
    step(); idle();
    chk("R10 trap beats eret", 32'(rpc), 32'(HPC));
    chk("R10 trap beats eret epc", 32'(epc), 32'h0A50);
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_ex_ovf();
    t_ex_sys();
    t_id_undef();
    t_busy_ignore();
    t_irq_masked();
    t_irq_ex();
    t_irq_id();
    t_irq_if();
    t_priority();
    t_ie_race();
    t_eret();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule